// File: doc/BRIEF.md
# Link-Up Stability Qualifier

This block turns a raw, asynchronous "link OK" level from the physical layer into a qualified link-up state. The raw level first crosses into the block clock through a two-stage synchronizer. The block reports the link as up only after the synchronized level has stayed high, with no break, for a period that a 3-bit code selects. Elapsed time is counted in pulses of a free-running one-microsecond tick. Any break in the level during qualification drops the progress made so far. A loss of link is reported without any qualification delay.

The periods form a fixed non-linear set. They range from no delay at all up to two seconds, so one block serves links that need fast bring-up and links that need long settling. The period code is captured only when a qualification run starts. A code change therefore acts at the next restart.

The controller is a three-state machine:
- LINK_DOWN: waiting for the synchronized level.
- LINK_QUAL: timing the stable interval.
- LINK_UP: qualified.

Its transitions are:
- DOWN→QUAL (start): the level is high and the code is nonzero.
- DOWN→UP (bypass): the level is high and the code is zero.
- QUAL→UP (settled): the tick count reaches the period.
- QUAL→DOWN (abort): the level goes low during qualification.
- UP→DOWN (loss): the level goes low while up.
- Every other state and input combination holds the current state.

Top module: `link_settle`

## Requirements
- R1: The raw level passes through two flip-flops before the state machine samples it. With code 0, a raw level that is first sampled high at clock edge e makes `link_up_o` high after edge e+2.
- R2: For a nonzero code, the period in microseconds is 500 for code 1, 1000 for code 2, 64000 for code 3, 256000 for code 4, 512000 for code 5, 1000000 for code 6 and 2000000 for code 7. The required tick count is that value shifted right by `PERIOD_SHIFT`, with a minimum of 1. `link_up_o` rises on the edge at which the T-th tick is sampled, counting ticks only after the edge on which qualification started.
- R3: Any edge at which the synchronized level is low during qualification returns the block to the down state. Qualification then restarts from a zero count.
- R4: Code 0 applies no qualification delay. The block goes up on the first edge at which the synchronized level is seen high.
- R5: `link_up_o` falls on the first edge at which the synchronized level is seen low, whatever the code.
- R6: Qualification advances only on edges where `tick_i` is high. Without ticks the link never qualifies, except with code 0.
- R7: The code is captured when qualification starts. A change of `period_code_i` during qualification or while up has no effect until the next restart.
- R8: `up_evt_o` and `dn_evt_o` are single-cycle pulses. They are high exactly in the cycle after `link_up_o` rises or falls, respectively, and never at the same time.
- R9: During and right after reset, `link_up_o`, `up_evt_o` and `dn_evt_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| raw_ok_i | input | 1 | Asynchronous raw link-OK level from the physical layer |
| tick_i | input | 1 | One-cycle pulse every microsecond, synchronous to clk_i |
| period_code_i | input | 3 | Selects the stable period |
| link_up_o | output | 1 | Qualified link-up level |
| up_evt_o | output | 1 | One-cycle pulse when the link becomes qualified |
| dn_evt_o | output | 1 | One-cycle pulse when the qualified link is lost |

## Verification
The bound checker verifies on every cycle the rules that involve only adjacent cycles:
- the events pulse for exactly one cycle, match each change of the qualified level, and never occur together;
- a low synchronized level forces the link down on the next edge;
- a missing tick stalls qualification;
- code 0 bypasses qualification.

Only the bench's scenarios can show the rules that span many cycles:
- the exact period for each code, counted tick by tick;
- a restart from zero after a one-cycle glitch;
- a mid-run code change being ignored until the next restart.

// File: rtl/link_settle_pkg.sv
package link_settle_pkg;

    localparam int CODE_W     = 3;
    localparam int MAX_US     = 2000000;
    localparam int RESET_CODE = 2;

    typedef enum logic [1:0] {
        LINK_DOWN = 2'd0,
        LINK_QUAL = 2'd1,
        LINK_UP   = 2'd2
    } link_st_e;

    // Stable period in microseconds for each selection code.
    function automatic int unsigned period_us(input logic [CODE_W-1:0] code);
        int unsigned v;
        unique case (code)
            3'd0:    v = 32'd0;
            3'd1:    v = 32'd500;
            3'd2:    v = 32'd1000;
            3'd3:    v = 32'd64000;
            3'd4:    v = 32'd256000;
            3'd5:    v = 32'd512000;
            3'd6:    v = 32'd1000000;
            default: v = 32'd2000000;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/link_settle_sync.sv
module link_settle_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q <= '0;
                else         chain_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q <= '0;
                else         chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/link_settle_period.sv
module link_settle_period
    import link_settle_pkg::*;
#(
    parameter int PERIOD_SHIFT = 0,
    parameter int CNT_W        = 21
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CNT_W-1:0]  ticks_o
);
    int unsigned scaled;

    always_comb begin
        scaled = period_us(code_i) >> PERIOD_SHIFT;
        if (code_i != '0 && scaled == 0) scaled = 1;
        ticks_o = CNT_W'(scaled);
    end
endmodule

// File: rtl/link_settle_timer.sv
module link_settle_timer #(
    parameter int               CNT_W     = 21,
    parameter logic [CNT_W-1:0] RST_TICKS = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] ticks_i,
    input  logic             run_i,
    input  logic             tick_i,
    output logic             hit_o
);
    logic [CNT_W-1:0] tgt_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_inc;

    // Period captured only at the start of a qualification run.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     tgt_q <= RST_TICKS;
        else if (load_i) tgt_q <= ticks_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (!run_i) cnt_q <= '0;
        else if (tick_i) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_inc = {1'b0, cnt_q} + 1'b1;
    assign hit_o   = run_i && tick_i && (cnt_inc >= {1'b0, tgt_q});
endmodule

// File: rtl/link_settle.sv
module link_settle
    import link_settle_pkg::*;
#(
    parameter int PERIOD_SHIFT = 0,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              raw_ok_i,
    input  logic              tick_i,
    input  logic [CODE_W-1:0] period_code_i,
    output logic              link_up_o,
    output logic              up_evt_o,
    output logic              dn_evt_o
);
    localparam int               CNT_W     = $clog2((MAX_US >> PERIOD_SHIFT) + 1);
    localparam logic [CNT_W-1:0] RST_TICKS = CNT_W'(period_us(CODE_W'(RESET_CODE)) >> PERIOD_SHIFT);

    logic             link_sync;
    logic [CNT_W-1:0] sel_ticks;
    logic             tmr_load;
    logic             tmr_run;
    logic             tmr_hit;
    link_st_e         state_q;
    link_st_e         state_d;

    link_settle_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (raw_ok_i),
        .q_o    (link_sync)
    );

    link_settle_period #(.PERIOD_SHIFT(PERIOD_SHIFT), .CNT_W(CNT_W)) u_period (
        .code_i  (period_code_i),
        .ticks_o (sel_ticks)
    );

    assign tmr_load = (state_q == LINK_DOWN) && link_sync;
    assign tmr_run  = (state_q == LINK_QUAL) && link_sync;

    link_settle_timer #(.CNT_W(CNT_W), .RST_TICKS(RST_TICKS)) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (tmr_load),
        .ticks_i (sel_ticks),
        .run_i   (tmr_run),
        .tick_i  (tick_i),
        .hit_o   (tmr_hit)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINK_DOWN: if (link_sync) state_d = (period_code_i == '0) ? LINK_UP : LINK_QUAL;
            LINK_QUAL: begin
                if (!link_sync)   state_d = LINK_DOWN;
                else if (tmr_hit) state_d = LINK_UP;
            end
            LINK_UP:   if (!link_sync) state_d = LINK_DOWN;
            default:   state_d = LINK_DOWN;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= LINK_DOWN;
        else         state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            link_up_o <= 1'b0;
            up_evt_o  <= 1'b0;
            dn_evt_o  <= 1'b0;
        end else begin
            link_up_o <= (state_d == LINK_UP);
            up_evt_o  <= (state_d == LINK_UP) && (state_q != LINK_UP);
            dn_evt_o  <= (state_q == LINK_UP) && (state_d != LINK_UP);
        end
    end
endmodule

// File: rtl/link_settle_chk.sv
module link_settle_chk
    import link_settle_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tick_i,
    input logic [CODE_W-1:0] code_i,
    input logic              sync_q,
    input link_st_e          state_q,
    input logic              link_up,
    input logic              up_evt,
    input logic              dn_evt
);
    p_up_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        up_evt |=> !up_evt);

    p_dn_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dn_evt |=> !dn_evt);

    p_evt_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(up_evt && dn_evt));

    p_rise_evt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(link_up) |-> up_evt);

    p_fall_evt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(link_up) |-> dn_evt);

    p_loss_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sync_q |=> !link_up);

    p_no_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == LINK_QUAL && !tick_i) |=> !link_up);

    p_bypass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == LINK_DOWN && sync_q && code_i == '0) |=> link_up);
endmodule

bind link_settle link_settle_chk u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .code_i  (period_code_i),
    .sync_q  (link_sync),
    .state_q (state_q),
    .link_up (link_up_o),
    .up_evt  (up_evt_o),
    .dn_evt  (dn_evt_o)
);

// File: tb/link_settle_test.sv
module link_settle_test;
    localparam int SHIFT = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       raw = 1'b0;
    logic       tick = 1'b0;
    logic [2:0] code = 3'd2;
    logic       link_up, up_evt, dn_evt;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;
    string phase = "R9";

    // Reference model state
    bit          d1, d2;
    int unsigned run_len, tk, tl;
    bit          exp_up, exp_prev;

    always #10 clk = ~clk;

    link_settle #(.PERIOD_SHIFT(SHIFT)) uut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .raw_ok_i      (raw),
        .tick_i        (tick),
        .period_code_i (code),
        .link_up_o     (link_up),
        .up_evt_o      (up_evt),
        .dn_evt_o      (dn_evt)
    );

    // Required tick count per code (R2)
    function automatic int unsigned need_ticks(input logic [2:0] c);
        int unsigned us;
        case (c)
            3'd0: us = 0;
            3'd1: us = 500;
            3'd2: us = 1000;
            3'd3: us = 64000;
            3'd4: us = 256000;
            3'd5: us = 512000;
            3'd6: us = 1000000;
            default: us = 2000000;
        endcase
        if (c == 3'd0) return 0;
        us = us >> SHIFT;
        return (us == 0) ? 1 : us;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            d1 = 0; d2 = 0; run_len = 0; tk = 0; tl = 0;
            exp_up = 0; exp_prev = 0;
        end else begin
            exp_prev = exp_up;
            if (d2) begin
                if (run_len == 0) begin
                    run_len = 1; tk = 0; tl = need_ticks(code);
                end else begin
                    run_len++;
                    if (tick) tk++;
                end
            end else begin
                run_len = 0;
            end
            d2 = d1;
            d1 = raw;
            exp_up = (run_len > 0) && (tl == 0 || tk >= tl);
        end
    end

    task automatic chk(input string what, input bit act, input bit exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", phase, what, act, exp, $time);
        end
    endtask

    task automatic step(input bit r, input bit t, input logic [2:0] c);
        @(negedge clk);
        chk("link_up", link_up, exp_up);
        chk("up_evt", up_evt, exp_up && !exp_prev);
        chk("dn_evt", dn_evt, !exp_up && exp_prev);
        raw = r; tick = t; code = c;
    endtask

    task automatic hold(input bit r, input int n, input logic [2:0] c);
        for (int i = 0; i < n; i++) step(r, 1'b1, c);
    endtask

    initial begin
        #(190000 * 20);
        if (!done) begin
            done = 1'b1;
            n_errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        // R9: outputs low in reset
        repeat (3) @(negedge clk);
        chk("link_up", link_up, 1'b0);
        chk("up_evt", up_evt, 1'b0);
        chk("dn_evt", dn_evt, 1'b0);
        rst_n = 1'b1;
        hold(0, 4, 3'd2);

        // R1 R4: code 0 passes through after the two sync stages
        phase = "R1_R4";
        hold(1, 6, 3'd0);
        hold(0, 6, 3'd0);

        // R2: every code, tick on every cycle
        phase = "R2";
        for (int c = 1; c < 8; c++) begin
            hold(1, need_ticks(3'(c)) + 8, 3'(c));
            hold(0, 5, 3'(c));
        end

        // R3: one-cycle glitch restarts qualification
        phase = "R3";
        hold(1, 5, 3'd1);
        hold(0, 1, 3'd1);
        hold(1, 20, 3'd1);
        hold(0, 5, 3'd1);

        // R5: loss while up, long code
        phase = "R5";
        hold(1, need_ticks(3'd3) + 5, 3'd3);
        hold(0, 1, 3'd3);
        hold(1, 10, 3'd3);
        hold(0, 5, 3'd3);

        // R6: no ticks, no progress
        phase = "R6";
        for (int i = 0; i < 60; i++) step(1, 1'b0, 3'd1);
        hold(1, 12, 3'd1);
        hold(0, 5, 3'd1);

        // R7: code change mid-run ignored; also while up
        phase = "R7";
        hold(1, 4, 3'd2);
        hold(1, 30, 3'd0);
        hold(1, 20, 3'd7);
        hold(0, 5, 3'd7);

        // R8: random traffic, random ticks
        phase = "R8";
        for (int k = 0; k < 300; k++) begin
            logic [2:0] c = 3'($urandom_range(0, 2));
            int len = $urandom_range(1, 40);
            for (int i = 0; i < len; i++)
                step(1, ($urandom_range(0, 3) != 0), c);
            len = $urandom_range(1, 5);
            for (int i = 0; i < len; i++)
                step(0, ($urandom_range(0, 1) != 0), 3'($urandom_range(0, 7)));
        end
        hold(0, 5, 3'd2);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end
endmodule